// File: doc/BRIEF.md
# Programmable Divided Countdown Timer

This block is a local countdown timer driven through a small indexed register port. Software sets a start value, a clock divider and an interrupt entry. The entry holds a vector, a mask flag and a repeat flag. The counter then steps down once per divided clock period. When the count reaches zero, the block raises a one-cycle interrupt request carrying the entry's vector, unless the entry is masked. In repeat mode the count passes through zero and reloads the start value on the following step. In single mode it stays at zero.

The divider code is three bits wide and is taken from non-adjacent bits of the divide register. The effective shift is the code plus one, wrapping in three bits, so the largest code means no division at all. A write of the start value restarts the countdown on the same clock edge. The register port is plain: a write strobe with index and data, and a separate read index whose data is returned combinationally. The receiver of the interrupt vector sits outside this block.

Top module: `pdc_timer`

## Requirements
- R1: The divide register (index 0x3E) keeps only write-data bits 3, 1 and 0, and reads back as the written value ANDed with 0xB.
- R2: The divide code is {bit3, bit1, bit0}. The shift is (code + 1) mod 8, and the count steps down once every 2^shift clocks, measured from the start-value write; code 7 steps every clock.
- R3: Writing the start value (index 0x38) loads the current count on that same edge and restarts the divider phase, discarding any countdown in progress.
- R4: In single mode (entry bit 17 clear), the count goes from the start value down to zero and then holds at zero.
- R5: In repeat mode (entry bit 17 set), the tick after the count reaches zero reloads the start value, so one period is start+1 ticks.
- R6: The interrupt pulse lasts exactly one cycle. It appears on the edge where the count becomes zero, and the vector output carries entry bits 7:0 at that moment.
- R7: When entry bit 16 (mask) is set, no pulse is produced, but the count keeps stepping.
- R8: A start value of zero leaves the count at zero and produces no pulse.
- R9: The current count (index 0x39) is read-only, and writes to it change nothing. The interrupt entry is at index 0x32. Unmapped indices read as zero, and writes to them are ignored.
- R10: After reset, all registers read zero, no pulse is active, and the divider uses code 0, which divides by 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 8 | Register index of the write |
| wr_data | input | 32 | Write data |
| rd_addr | input | 8 | Register index of the read |
| rd_data | output | 32 | Read data, combinational from rd_addr |
| irq_pulse | output | 1 | One-cycle expiry request |
| irq_vector | output | 8 | Vector that goes with irq_pulse |

## Verification
Let E0 be the edge that samples a start-value write. The current count reads the new value right after E0, and the j-th step lands on edge E0 + j·2^shift. The pulse is registered on the same edge as the step that reaches zero. In repeat mode, later pulses follow every (start+1)·2^shift edges. The bench records the cycle count just after E0, and the driver queues the exact expiry cycle and vector. A monitor samples on falling edges, pops each pulse and compares its cycle and vector. Count reads are likewise taken on the falling edge at a computed cycle offset. Register reads are combinational, so each is checked one time unit after its index is applied.

// File: rtl/pdc_timer_pkg.sv
package pdc_timer_pkg;
  localparam int IDX_W  = 8;
  localparam int VEC_W  = 8;
  localparam int CODE_W = 3;

  localparam logic [IDX_W-1:0] IDX_ENTRY = 8'h32;
  localparam logic [IDX_W-1:0] IDX_START = 8'h38;
  localparam logic [IDX_W-1:0] IDX_COUNT = 8'h39;
  localparam logic [IDX_W-1:0] IDX_DIV   = 8'h3E;

  localparam int ENTRY_MASK_BIT   = 16;
  localparam int ENTRY_REPEAT_BIT = 17;

  typedef struct packed {
    logic             repeat_en;
    logic             masked;
    logic [VEC_W-1:0] vector;
  } entry_t;
endpackage

// File: rtl/pdc_timer_regs.sv
module pdc_timer_regs
  import pdc_timer_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [IDX_W-1:0]  rd_addr,
  output logic [DATA_W-1:0] rd_data,
  input  logic [DATA_W-1:0] count_i,
  output logic [DATA_W-1:0] start_o,
  output logic [CODE_W-1:0] shift_o,
  output entry_t            entry_o,
  output logic              load_o
);
  logic [CODE_W-1:0] code_q;
  logic [DATA_W-1:0] start_q;
  entry_t            entry_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      code_q  <= '0;
      start_q <= '0;
      entry_q <= '0;
    end else if (wr_en) begin
      case (wr_addr)
        IDX_START: start_q <= wr_data;
        IDX_DIV:   code_q  <= {wr_data[3], wr_data[1:0]};
        IDX_ENTRY: begin
          entry_q.repeat_en <= wr_data[ENTRY_REPEAT_BIT];
          entry_q.masked    <= wr_data[ENTRY_MASK_BIT];
          entry_q.vector    <= wr_data[VEC_W-1:0];
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    rd_data = '0;
    case (rd_addr)
      IDX_START: rd_data = start_q;
      IDX_COUNT: rd_data = count_i;
      IDX_DIV: begin
        rd_data[3]   = code_q[2];
        rd_data[1:0] = code_q[1:0];
      end
      IDX_ENTRY: begin
        rd_data[ENTRY_REPEAT_BIT] = entry_q.repeat_en;
        rd_data[ENTRY_MASK_BIT]   = entry_q.masked;
        rd_data[VEC_W-1:0]        = entry_q.vector;
      end
      default: rd_data = '0;
    endcase
  end

  assign start_o = start_q;
  assign shift_o = code_q + CODE_W'(1);
  assign entry_o = entry_q;
  assign load_o  = wr_en && (wr_addr == IDX_START);

  p_count_write_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == IDX_COUNT) |=> ($stable(start_q) && $stable(code_q) && $stable(entry_q)));
endmodule

// File: rtl/pdc_timer_prescale.sv
module pdc_timer_prescale
  import pdc_timer_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              restart,
  input  logic [CODE_W-1:0] shift,
  output logic              tick
);
  localparam int PRE_W = (1 << CODE_W) - 1;

  logic [PRE_W-1:0] phase_q;
  logic [PRE_W-1:0] span;

  for (genvar g = 0; g < PRE_W; g++) begin : g_span
    assign span[g] = (CODE_W'(g) < shift);
  end

  always_ff @(posedge clk) begin
    if (!rst_n || restart) phase_q <= '0;
    else                   phase_q <= phase_q + PRE_W'(1);
  end

  assign tick = &(phase_q | ~span);

  p_tick_gap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && shift != '0 && !restart) |=> (!tick || shift != $past(shift)));
endmodule

// File: rtl/pdc_timer_count.sv
module pdc_timer_count
  import pdc_timer_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic [CNT_W-1:0] start_val,
  input  logic             tick,
  input  entry_t           entry,
  output logic [CNT_W-1:0] count_o,
  output logic             irq_o,
  output logic [VEC_W-1:0] vec_o
);
  logic [CNT_W-1:0] count_q;
  logic             irq_q;
  logic [VEC_W-1:0] vec_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count_q <= '0;
      irq_q   <= 1'b0;
      vec_q   <= '0;
    end else begin
      irq_q <= 1'b0;
      if (load) begin
        count_q <= load_val;
      end else if (tick) begin
        if (count_q == '0) begin
          if (entry.repeat_en) count_q <= start_val;
        end else begin
          count_q <= count_q - CNT_W'(1);
          if (count_q == CNT_W'(1) && !entry.masked) begin
            irq_q <= 1'b1;
            vec_q <= entry.vector;
          end
        end
      end
    end
  end

  assign count_o = count_q;
  assign irq_o   = irq_q;
  assign vec_o   = vec_q;

  p_load_value_r3: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (count_q == $past(load_val)));
  p_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && tick && count_q != '0) |=> (count_q == $past(count_q) - CNT_W'(1)));
  p_single_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && count_q == '0 && !entry.repeat_en) |=> (count_q == '0));
  p_reload_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && tick && count_q == '0 && entry.repeat_en) |=> (count_q == $past(start_val)));
  p_pulse_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q |=> !irq_q);
  p_pulse_at_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q |-> (count_q == '0));
  p_mask_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q |-> !$past(entry.masked));
  p_zero_start_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (load && load_val == '0) |=> (!irq_q && count_q == '0));
endmodule

// File: rtl/pdc_timer.sv
module pdc_timer
  import pdc_timer_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [7:0]        wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [7:0]        rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic              irq_pulse,
  output logic [7:0]        irq_vector
);
  logic [DATA_W-1:0] count;
  logic [DATA_W-1:0] start;
  logic [CODE_W-1:0] shift;
  entry_t            entry;
  logic              load;
  logic              tick;

  pdc_timer_regs #(.DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .count_i(count), .start_o(start),
    .shift_o(shift), .entry_o(entry), .load_o(load)
  );

  pdc_timer_prescale u_pre (
    .clk(clk), .rst_n(rst_n), .restart(load), .shift(shift), .tick(tick)
  );

  pdc_timer_count #(.CNT_W(DATA_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .load(load), .load_val(wr_data), .start_val(start),
    .tick(tick), .entry(entry), .count_o(count), .irq_o(irq_pulse), .vec_o(irq_vector)
  );
endmodule

// File: tb/pdc_timer_tb.sv
module pdc_timer_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [7:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [7:0]  rd_addr = '0;
  logic [31:0] rd_data;
  logic        irq_pulse;
  logic [7:0]  irq_vector;

  always #10 clk = ~clk;

  pdc_timer u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .irq_pulse(irq_pulse), .irq_vector(irq_vector)
  );

  typedef struct { int at; int vec; } exp_t;
  exp_t expq[$];
  int cyc = 0;
  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(string req, string what, longint act, longint exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d, output int c0);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    c0 = cyc;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    rd_addr = a;
    #1;
    d = rd_data;
  endtask

  task automatic wait_to(input int target);
    while (cyc < target) @(negedge clk);
  endtask

  task automatic expect_pulse(input int at, input int vec);
    exp_t e;
    e.at = at; e.vec = vec;
    expq.push_back(e);
  endtask

  // Monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n && irq_pulse) begin
      if (expq.size() == 0) begin
        n_chk++; n_fail++;
        $display("FAIL R7 unexpected pulse at cycle %0d: actual 1 expected 0", cyc);
      end else begin
        exp_t e;
        e = expq.pop_front();
        chk("R6", "pulse cycle", cyc, e.at);
        chk("R6", "pulse vector", irq_vector, e.vec);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    int c0, c1;
    logic [31:0] d;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R10 reset state
    rd(8'h38, d); chk("R10", "start reset", d, 0);
    rd(8'h39, d); chk("R10", "count reset", d, 0);
    rd(8'h3E, d); chk("R10", "div reset", d, 0);
    rd(8'h32, d); chk("R10", "entry reset", d, 0);
    chk("R10", "pulse reset", irq_pulse, 0);

    // R10/R2 reset divider divides by 2, single mode
    wr(8'h32, 32'h0000_0041, c0);
    wr(8'h38, 32'd3, c0);
    expect_pulse(c0 + 6, 8'h41);
    wait_to(c0 + 1); rd(8'h39, d); chk("R2", "div2 count at +1", d, 3);
    wait_to(c0 + 2); rd(8'h39, d); chk("R2", "div2 count at +2", d, 2);
    wait_to(c0 + 10);

    // R1 divide bits
    wr(8'h3E, 32'hFFFF_FFFF, c0);
    rd(8'h3E, d); chk("R1", "div readback", d, 32'hB);

    // R4 single mode, code 7 = every clock
    wr(8'h38, 32'd5, c0);
    expect_pulse(c0 + 5, 8'h41);
    wait_to(c0 + 2); rd(8'h39, d); chk("R2", "div1 count at +2", d, 3);
    wait_to(c0 + 20); rd(8'h39, d); chk("R4", "single holds zero", d, 0);

    // R9 read-only count and unmapped index
    wr(8'h39, 32'h55, c0);
    rd(8'h39, d); chk("R9", "count write ignored", d, 0);
    wr(8'h40, 32'h1234, c0);
    rd(8'h40, d); chk("R9", "unmapped reads zero", d, 0);
    rd(8'h38, d); chk("R9", "start unchanged", d, 5);
    rd(8'h32, d); chk("R9", "entry readback", d, 32'h41);

    // R3 restart mid-count
    wr(8'h38, 32'd10, c0);
    wait_to(c0 + 4); rd(8'h39, d); chk("R3", "count mid", d, 6);
    wr(8'h38, 32'd6, c1);
    rd(8'h39, d); chk("R3", "reloaded", d, 6);
    expect_pulse(c1 + 6, 8'h41);
    wait_to(c1 + 15);

    // R7 masked: counting continues, no pulse
    wr(8'h32, 32'h0001_0077, c0);
    wr(8'h38, 32'd4, c0);
    wait_to(c0 + 4);
    rd(8'h39, d); chk("R7", "masked count zero", d, 0);
    chk("R7", "masked no pulse", irq_pulse, 0);
    wait_to(c0 + 10);

    // R5 repeat mode, code 7
    wr(8'h32, 32'h0002_0062, c0);
    wr(8'h38, 32'd3, c0);
    expect_pulse(c0 + 3, 8'h62);
    expect_pulse(c0 + 7, 8'h62);
    expect_pulse(c0 + 11, 8'h62);
    wait_to(c0 + 3); rd(8'h39, d); chk("R5", "passes zero", d, 0);
    wait_to(c0 + 4); rd(8'h39, d); chk("R5", "reloads start", d, 3);
    wait_to(c0 + 12);
    // R8 zero start stops it
    wr(8'h38, 32'd0, c1);
    rd(8'h39, d); chk("R8", "zero start count", d, 0);
    wait_to(c1 + 20);
    rd(8'h39, d); chk("R8", "stays zero", d, 0);

    // R5/R2 repeat mode with divide by 2
    wr(8'h3E, 32'h0, c0);
    wr(8'h38, 32'd2, c0);
    expect_pulse(c0 + 4, 8'h62);
    expect_pulse(c0 + 10, 8'h62);
    wait_to(c0 + 11);
    wr(8'h38, 32'd0, c1);
    wait_to(c1 + 20);

    // R2 code from bit 3: 0x8 -> code 4 -> shift 5
    wr(8'h32, 32'h0000_0055, c0);
    wr(8'h3E, 32'h8, c0);
    wr(8'h38, 32'd2, c0);
    expect_pulse(c0 + 64, 8'h55);
    wait_to(c0 + 31); rd(8'h39, d); chk("R2", "div32 before step", d, 2);
    wait_to(c0 + 32); rd(8'h39, d); chk("R2", "div32 first step", d, 1);
    wait_to(c0 + 80);

    chk("R6", "pending expected pulses", expq.size(), 0);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule